// File: doc/BRIEF.md
# Hold-Until-Release Priority Arbiter

This block shares one resource among several devices. Each device raises its own request line while it needs the resource, and it is handed a matching grant line when the resource is free. If several devices ask at the same moment, the one with the lowest index wins, because index 0 has the highest priority. Once a device holds the grant, it keeps it for as long as its request stays high. Requests from other devices make no difference to a grant already issued, whatever their priority.

The block is a Moore machine with one Idle state and one owner state per device. Grants are decoded from the state register alone. When an owner drops its request, the machine always passes through Idle for one cycle before it issues the next grant, so a clock edge with no owner always separates two owners. A parameter sets the number of devices (three by default, eight or more supported). A second parameter picks how the state is stored: as a compact binary code, or as one-hot with the Idle bit kept inverted, so that the all-zero register means Idle. Both choices behave the same at the ports.

Request and grant are plain level signals with no valid/ready handshake. A device signals that it is finished only by dropping its request.

Top module: `hold_arbiter`

## Requirements
- R1: A synchronous active-high reset puts the machine in Idle, and every grant bit is 0 on the first clock edge that samples reset high, even in the middle of a grant.
- R2: At most one bit of `gnt` is 1 in any cycle.
- R3: In Idle with `req` all zero, `gnt` stays all zero after the next edge.
- R4: In Idle with any `req` bit set, the next edge sets exactly `gnt[k]`, where k is the lowest set index in `req` (bit 0 is the highest priority).
- R5: While `gnt[k]` is 1 and `req[k]` is 1, `gnt[k]` stays 1 after the next edge, whatever the other `req` bits are, including those with higher priority.
- R6: While `gnt[k]` is 1 and `req[k]` is 0, the next edge clears all of `gnt`, even if other requests are pending. A new grant can appear no earlier than the edge after that.
- R7: Both encodings (`ENC` = `ENC_BINARY` or `ENC_ONEHOT`) give identical `gnt` sequences for the same `req` sequence.
- R8: With `N_DEV` = 8, rules R4 to R6 hold across all eight lines, including the lowest-priority line 7 and the hand-over from line 0 to line 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to Idle |
| req | input | N_DEV | Request line per device, bit 0 highest priority |
| gnt | output | N_DEV | Grant line per device, decoded from state |

## Verification
On every cycle, assertions inside the RTL check the following:
- no more than one grant is ever high;
- a reset edge clears the grants;
- Idle with no requests stays Idle;
- the first grant out of Idle goes to the lowest set request;
- a held request keeps its grant;
- a dropped request yields a cycle with no owner.

Only the bench's scenarios can show that the two encodings match each other edge for edge, that the wide eight-device configuration reaches its lowest-priority line, and that requests with higher priority are truly ignored during a hold. The bench walks sequences with known expected grants to show these.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // How the state register is stored.
  typedef enum logic {
    ENC_BINARY = 1'b0,  // 0 = Idle, k+1 = owner k
    ENC_ONEHOT = 1'b1   // bit 0 = inverted Idle flag, bit k+1 = owner k
  } arb_enc_e;
endpackage

// File: rtl/arb_pick.sv
// Fixed-priority pick: isolate the lowest set request bit.
module arb_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  always_comb pick = req & (~req + N'(1));
endmodule

// File: rtl/arb_state.sv
// State storage. Takes and returns the abstract grant vector (all zero = Idle).
module arb_state
  import arb_pkg::*;
#(
  parameter int       N   = 3,
  parameter arb_enc_e ENC = ENC_BINARY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] nxt_gnt,
  output logic [N-1:0] cur_gnt,
  output logic         legal
);
  generate
    if (ENC == ENC_BINARY) begin : g_bin
      localparam int SW = $clog2(N + 1);
      logic [SW-1:0] st_q, st_d;
      logic [N-1:0]  dec;

      always_comb begin
        st_d = '0;
        for (int k = 0; k < N; k++)
          if (nxt_gnt[k]) st_d = st_d | SW'(k + 1);
      end

      always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
      end

      always_comb begin
        for (int k = 0; k < N; k++) dec[k] = (st_q == SW'(k + 1));
      end

      // Codes above N decode to no owner and are flagged for recovery.
      assign legal   = (st_q == '0) || (|dec);
      assign cur_gnt = dec;
    end else begin : g_onehot
      logic [N:0] st_q, st_d;

      // Bit 0 holds "not idle", so the reset value of zero is Idle.
      always_comb st_d = {nxt_gnt, |nxt_gnt};

      always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
      end

      assign legal   = (st_q == '0) || (st_q[0] && $onehot(st_q[N:1]));
      assign cur_gnt = (legal && st_q[0]) ? st_q[N:1] : '0;
    end
  endgenerate
endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import arb_pkg::*;
#(
  parameter int       N_DEV = 3,
  parameter arb_enc_e ENC   = ENC_BINARY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DEV-1:0] req,
  output logic [N_DEV-1:0] gnt
);
  logic [N_DEV-1:0] cur_gnt, nxt_gnt, pick;
  logic             legal, owned, held;

  arb_pick #(.N(N_DEV)) u_pick (
    .req  (req),
    .pick (pick)
  );

  arb_state #(.N(N_DEV), .ENC(ENC)) u_state (
    .clk     (clk),
    .rst     (rst),
    .nxt_gnt (nxt_gnt),
    .cur_gnt (cur_gnt),
    .legal   (legal)
  );

  assign owned = |cur_gnt;
  assign held  = |(cur_gnt & req);

  // Next state: an illegal code recovers to Idle; an owner keeps the grant
  // while its own request is high; Idle serves the highest-priority request.
  always_comb begin
    if (!legal)     nxt_gnt = '0;
    else if (owned) nxt_gnt = held ? cur_gnt : '0;
    else            nxt_gnt = pick;
  end

  assign gnt = cur_gnt;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (gnt == '0));                                          // R1
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));                                                // R2
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> (gnt == '0));                     // R3
  AST_PRIORITY_PICK: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req != '0) |=>
      (gnt == ($past(req) & (~$past(req) + N_DEV'(1)))));          // R4
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
    (|(gnt & req)) |=> (gnt == $past(gnt)));                       // R5
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));             // R6
endmodule

// File: tb/sim_hold_arbiter.sv
module sim_hold_arbiter;
  import arb_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req = '0;
  logic [2:0] g0, g1;
  logic [7:0] req8 = '0;
  logic [7:0] g8;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;  // 100 MHz

  hold_arbiter #(.N_DEV(3), .ENC(ENC_BINARY)) u0 (.clk(clk), .rst(rst), .req(req),  .gnt(g0));
  hold_arbiter #(.N_DEV(3), .ENC(ENC_ONEHOT)) u1 (.clk(clk), .rst(rst), .req(req),  .gnt(g1));
  hold_arbiter #(.N_DEV(8), .ENC(ENC_ONEHOT)) u2 (.clk(clk), .rst(rst), .req(req8), .gnt(g8));

  // Each entry is {req[2:0], expected gnt[2:0] after the edge}. Bit 0 has top priority.
  localparam int NV = 17;
  localparam logic [5:0] VECS [NV] = '{
    6'b000_000, // R3 idle stays idle
    6'b110_010, // R4 lowest set bit wins
    6'b111_010, // R5 hold, higher priority ignored
    6'b101_000, // R6 release passes through idle
    6'b101_001, // R4 then bit 0 wins
    6'b100_000, // R6
    6'b100_100, // R4 lowest priority alone
    6'b110_100, // R5 hold against bit 1
    6'b011_000, // R6
    6'b011_001, // R4
    6'b010_000, // R6
    6'b010_010, // R4
    6'b000_000, // R6
    6'b000_000, // R3
    6'b001_001, // R4
    6'b001_001, // R5
    6'b000_000  // R6
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step3(input logic [2:0] r);
    @(negedge clk);
    req = r;
    @(posedge clk);
    #1;
  endtask

  task automatic step8(input logic [7:0] r);
    @(negedge clk);
    req8 = r;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset binary", {5'b0, g0}, 8'h00);
    chk("R1 reset onehot", {5'b0, g1}, 8'h00);
    chk("R1 reset wide",   g8,         8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step3(VECS[i][5:3]);
      chk($sformatf("R3/R4/R5/R6 vec %0d", i), {5'b0, g0}, {5'b0, VECS[i][2:0]});
      chk($sformatf("R7 vec %0d", i), {5'b0, g1}, {5'b0, g0});
      chk("R2 onehot0", {7'b0, $onehot0(g0)}, 8'h01);
    end

    // R1: reset in the middle of a held grant
    step3(3'b100);
    chk("R4 pre-reset", {5'b0, g0}, 8'h04);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 mid-grant binary", {5'b0, g0}, 8'h00);
    chk("R1 mid-grant onehot", {5'b0, g1}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R4 after reset", {5'b0, g0}, 8'h04);
    chk("R7 after reset", {5'b0, g1}, {5'b0, g0});
    step3(3'b000);
    chk("R6 drop", {5'b0, g0}, 8'h00);

    // R8: eight devices
    step8(8'h80);  chk("R8 lowest line",   g8, 8'h80);
    step8(8'hFF);  chk("R8 hold",          g8, 8'h80);
    step8(8'h7F);  chk("R8 release gap",   g8, 8'h00);
    step8(8'h7F);  chk("R8 priority",      g8, 8'h01);
    step8(8'h7E);  chk("R8 release gap 2", g8, 8'h00);
    step8(8'h7E);  chk("R8 next owner",    g8, 8'h02);
    step8(8'h00);  chk("R8 drop",          g8, 8'h00);
    step8(8'h00);  chk("R8 idle",          g8, 8'h00);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule